// File: doc/BRIEF.md
# Event Ring Enqueue Engine

This block is one interrupter of a host-controller event path. Producers inside the controller hand it event records. Each record holds a 64-bit pointer, a 32-bit status word, a 32-bit control word and a target index. The block writes each accepted event as a 16-byte entry into an event ring in memory. That ring is made of segments, and the segments are listed in a segment table that software builds in memory. The block walks this table through a request/acknowledge memory port. After each successful write it sets an interrupt-pending flag and, if interrupts are enabled, raises a one-cycle interrupt pulse.

Software programs the block through a plain 32-bit register port. A set of eight words holds:
- the management bits,
- a stored moderation word,
- the table size,
- the 64-bit table base,
- the 64-bit dequeue pointer.

Writing the upper half of the table base restarts the table walk. The next event then first fetches the table entry at the base address. When the current segment is full, the block moves to the next table entry. When it runs past the last table entry, it wraps back to the first one. A controller reset input clears every register and all ring state.

Top module: `event_ring_enqueue`

## Requirements
- R1: Register words are decoded from byte address bits [4:2]: management 0x00, moderation 0x04, table size 0x08, table base low/high 0x10/0x14, dequeue low/high 0x18/0x1C. The moderation, table size, table base and dequeue words read back what was written, and 0x0C reads zero.
- R2: In the management word, bit 0 is pending and bit 1 is enable. Writing 1 to bit 0 clears pending, and writing 0 to it leaves pending unchanged. Bit 1 is a plain read/write bit.
- R3: After a write to the table base high word, the next event first issues a memory read at the full 64-bit table base, and only then its event write.
- R4: A table entry is returned in the 128-bit read data. Bits [63:0] are the segment base, used with bits [5:0] forced to zero. Bits [79:64] are the segment size in 16-byte entries. After a fetch, the event is written at the new segment base.
- R5: An event write goes to the enqueue pointer. Its 128-bit write data holds the pointer in bits [63:0], the status word in [95:64] and the control word in [127:96].
- R6: A successful event write advances the enqueue pointer by 16 and sets pending. A one-cycle irq pulse follows only when enable is 1.
- R7: When the enqueue pointer has reached segment base + size×16, the next event reads the table entry 16 bytes after the current one before it writes.
- R8: If the advanced entry address reaches table base + table size×16, the read goes instead to the table base with bits [3:0] cleared.
- R9: An event whose target index is at or above INTR_COUNT is accepted and dropped. It causes no memory access and leaves pending unchanged.
- R10: An event write answered with an error leaves the enqueue pointer and pending unchanged. The next event is written at the same address.
- R11: A table read answered with an error drops that event and leaves the walk state unchanged. The next event reads the same table address again.
- R12: A one-cycle controller reset clears all register words and the ring state.
- R13: evtReady is low from the cycle after an event is accepted until its memory transactions have finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrlReset | input | 1 | Synchronous controller reset, clears registers and ring state |
| regAddr | input | 5 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| evtValid | input | 1 | Event record valid |
| evtReady | output | 1 | Block can accept an event |
| evtPtr | input | 64 | Event pointer field |
| evtStatus | input | 32 | Event status word |
| evtControl | input | 32 | Event control word |
| evtTarget | input | 10 | Target interrupter index |
| memReq | output | 1 | Memory request, held until memAck |
| memWrite | output | 1 | 1 for event write, 0 for table read |
| memAddr | output | 64 | Memory byte address |
| memWrData | output | 128 | Event entry data |
| memAck | input | 1 | Memory acknowledge, one cycle |
| memErr | input | 1 | Memory error, valid with memAck |
| memRdData | input | 128 | Table entry data, valid with memAck |
| irq | output | 1 | Interrupt pulse |

## Verification
An accepted event moves to the decide state on the next edge, and its memory request appears one edge after that. The bench memory answers half a cycle after it sees a request, and the design consumes that acknowledge on the following rising edge. The pointer, the pending bit and the irq pulse all change on that acknowledging edge. The bench therefore waits for evtReady to return high, steps one more falling edge, and only then reads registers or compares transaction logs. The irq pulse is counted on every falling edge, so one pulse is counted exactly once. Register reads are combinational and are sampled 1 ns after the address is set at a falling edge.

// File: rtl/evq_pkg.sv
package evq_pkg;
  // Word index taken from byte address bits [4:2]
  localparam logic [2:0] WORD_MGMT     = 3'd0;
  localparam logic [2:0] WORD_MOD      = 3'd1;
  localparam logic [2:0] WORD_TSIZE    = 3'd2;
  localparam logic [2:0] WORD_TBASE_LO = 3'd4;
  localparam logic [2:0] WORD_TBASE_HI = 3'd5;
  localparam logic [2:0] WORD_DEQ_LO   = 3'd6;
  localparam logic [2:0] WORD_DEQ_HI   = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_FETCH,
    ST_WRITE
  } evqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchEvt;
    logic loadFetch;
    logic loadWrite;
    logic commitFetch;
    logic commitWrite;
  } evqStrobe_t;
endpackage

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
#(
  parameter int TGT_W      = 10,
  parameter int INTR_COUNT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrlReset,
  input  logic             evtValid,
  input  logic [TGT_W-1:0] evtTarget,
  output logic             evtReady,
  input  logic             fetchNeeded,
  input  logic             memAck,
  input  logic             memErr,
  output logic             memReq,
  output logic             memWrite,
  output evqStrobe_t       strobe
);
  localparam logic [TGT_W-1:0] TGT_LIMIT = TGT_W'(INTR_COUNT);

  evqState_t state, stateNext;
  logic      targetOk;

  assign targetOk = evtTarget < TGT_LIMIT;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    evtReady  = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        evtReady = 1'b1;
        if (evtValid && targetOk) begin
          strobe.latchEvt = 1'b1;
          stateNext       = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (fetchNeeded) begin
          strobe.loadFetch = 1'b1;
          stateNext        = ST_FETCH;
        end else begin
          strobe.loadWrite = 1'b1;
          stateNext        = ST_WRITE;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            stateNext = ST_IDLE;
          end else begin
            strobe.commitFetch = 1'b1;
            strobe.loadWrite   = 1'b1;
            stateNext          = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memAck) begin
          strobe.commitWrite = !memErr;
          stateNext          = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (ctrlReset) begin
      strobe    = '0;
      stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end
endmodule

// File: rtl/evq_datapath.sv
module evq_datapath
  import evq_pkg::*;
#(
  parameter int PTR_W  = 64,
  parameter int WORD_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrlReset,
  input  logic [4:0]          regAddr,
  input  logic                regWrEn,
  input  logic [WORD_W-1:0]   regWrData,
  output logic [WORD_W-1:0]   regRdData,
  input  logic [PTR_W-1:0]    evtPtr,
  input  logic [WORD_W-1:0]   evtStatus,
  input  logic [WORD_W-1:0]   evtControl,
  input  evqStrobe_t          strobe,
  output logic                fetchNeeded,
  output logic [PTR_W-1:0]    memAddr,
  output logic [PTR_W+2*WORD_W-1:0] memWrData,
  input  logic [PTR_W+2*WORD_W-1:0] memRdData,
  output logic                irq
);
  localparam int ENTRY_SHIFT = 4;
  localparam logic [PTR_W-1:0] ENTRY_BYTES = PTR_W'(1) << ENTRY_SHIFT;
  localparam logic [PTR_W-1:0] SEG_MASK    = ~(PTR_W'(63));
  localparam logic [PTR_W-1:0] ENTRY_MASK  = ~(ENTRY_BYTES - PTR_W'(1));

  logic              pending, enable;
  logic [WORD_W-1:0] moderation, tblSize;
  logic [PTR_W-1:0]  tblBase, deqPtr;
  logic [PTR_W-1:0]  entryPtr, pendEntry, segBase, enqPtr, reqAddr;
  logic [SIZE_W-1:0] segSize;
  logic              needFetch;
  logic [PTR_W-1:0]  evtPtrQ;
  logic [WORD_W-1:0] evtStsQ, evtCtlQ;

  logic [PTR_W-1:0]  segEnd, tblEnd, advEntry, candEntry, newBase;
  logic              segFull;
  logic [2:0]        wordSel;
  logic              unusedBits;

  assign wordSel     = regAddr[4:2];
  assign unusedBits  = ^{regAddr[1:0], memRdData[PTR_W+2*WORD_W-1:PTR_W+SIZE_W]};
  assign segEnd      = segBase + (PTR_W'(segSize) << ENTRY_SHIFT);
  assign segFull     = enqPtr >= segEnd;
  assign tblEnd      = tblBase + (PTR_W'(tblSize) << ENTRY_SHIFT);
  assign advEntry    = entryPtr + ENTRY_BYTES;
  assign candEntry   = needFetch ? entryPtr
                     : (advEntry >= tblEnd) ? (tblBase & ENTRY_MASK) : advEntry;
  assign fetchNeeded = needFetch || segFull;
  assign newBase     = memRdData[PTR_W-1:0] & SEG_MASK;
  assign memAddr     = reqAddr;
  assign memWrData   = {evtCtlQ, evtStsQ, evtPtrQ};

  always_comb begin
    unique case (wordSel)
      WORD_MGMT:     regRdData = {{(WORD_W-2){1'b0}}, enable, pending};
      WORD_MOD:      regRdData = moderation;
      WORD_TSIZE:    regRdData = tblSize;
      WORD_TBASE_LO: regRdData = tblBase[WORD_W-1:0];
      WORD_TBASE_HI: regRdData = tblBase[PTR_W-1:WORD_W];
      WORD_DEQ_LO:   regRdData = deqPtr[WORD_W-1:0];
      WORD_DEQ_HI:   regRdData = deqPtr[PTR_W-1:WORD_W];
      default:       regRdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0; enable <= 1'b0; moderation <= '0; tblSize <= '0;
      tblBase <= '0; deqPtr <= '0; entryPtr <= '0; pendEntry <= '0;
      segBase <= '0; segSize <= '0; enqPtr <= '0; reqAddr <= '0;
      needFetch <= 1'b0; evtPtrQ <= '0; evtStsQ <= '0; evtCtlQ <= '0;
      irq <= 1'b0;
    end else if (ctrlReset) begin
      pending <= 1'b0; enable <= 1'b0; moderation <= '0; tblSize <= '0;
      tblBase <= '0; deqPtr <= '0; entryPtr <= '0; pendEntry <= '0;
      segBase <= '0; segSize <= '0; enqPtr <= '0; reqAddr <= '0;
      needFetch <= 1'b0; evtPtrQ <= '0; evtStsQ <= '0; evtCtlQ <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (strobe.latchEvt) begin
        evtPtrQ <= evtPtr;
        evtStsQ <= evtStatus;
        evtCtlQ <= evtControl;
      end
      if (strobe.loadFetch) begin
        pendEntry <= candEntry;
        reqAddr   <= candEntry;
      end
      if (strobe.commitFetch) begin
        entryPtr  <= pendEntry;
        needFetch <= 1'b0;
        segBase   <= newBase;
        segSize   <= memRdData[PTR_W+SIZE_W-1:PTR_W];
        enqPtr    <= newBase;
      end
      if (strobe.loadWrite) reqAddr <= strobe.commitFetch ? newBase : enqPtr;
      if (strobe.commitWrite) begin
        enqPtr <= enqPtr + ENTRY_BYTES;
        irq    <= enable;
      end
      if (regWrEn) begin
        unique case (wordSel)
          WORD_MGMT: begin
            enable <= regWrData[1];
            if (regWrData[0]) pending <= 1'b0;
          end
          WORD_MOD:      moderation <= regWrData;
          WORD_TSIZE:    tblSize <= regWrData;
          WORD_TBASE_LO: tblBase[WORD_W-1:0] <= regWrData;
          WORD_TBASE_HI: begin
            tblBase[PTR_W-1:WORD_W] <= regWrData;
            entryPtr  <= {regWrData, tblBase[WORD_W-1:0]};
            needFetch <= 1'b1;
          end
          WORD_DEQ_LO:   deqPtr[WORD_W-1:0] <= regWrData;
          WORD_DEQ_HI:   deqPtr[PTR_W-1:WORD_W] <= regWrData;
          default: ;
        endcase
      end
      // hardware set wins over a same-cycle clear
      if (strobe.commitWrite) pending <= 1'b1;
    end
  end
endmodule

// File: rtl/event_ring_enqueue.sv
module event_ring_enqueue
  import evq_pkg::*;
#(
  parameter int TGT_W      = 10,
  parameter int INTR_COUNT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrlReset,
  input  logic [4:0]   regAddr,
  input  logic         regWrEn,
  input  logic [31:0]  regWrData,
  output logic [31:0]  regRdData,
  input  logic         evtValid,
  output logic         evtReady,
  input  logic [63:0]  evtPtr,
  input  logic [31:0]  evtStatus,
  input  logic [31:0]  evtControl,
  input  logic [TGT_W-1:0] evtTarget,
  output logic         memReq,
  output logic         memWrite,
  output logic [63:0]  memAddr,
  output logic [127:0] memWrData,
  input  logic         memAck,
  input  logic         memErr,
  input  logic [127:0] memRdData,
  output logic         irq
);
  evqStrobe_t strobe;
  logic       fetchNeeded;

  evq_ctrl #(.TGT_W(TGT_W), .INTR_COUNT(INTR_COUNT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrlReset(ctrlReset),
    .evtValid(evtValid), .evtTarget(evtTarget), .evtReady(evtReady),
    .fetchNeeded(fetchNeeded), .memAck(memAck), .memErr(memErr),
    .memReq(memReq), .memWrite(memWrite), .strobe(strobe)
  );

  evq_datapath #(.PTR_W(64), .WORD_W(32), .SIZE_W(16)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrlReset(ctrlReset),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .evtPtr(evtPtr), .evtStatus(evtStatus),
    .evtControl(evtControl), .strobe(strobe), .fetchNeeded(fetchNeeded),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData),
    .irq(irq)
  );
endmodule

// File: rtl/event_ring_enqueue_checker.sv
module event_ring_enqueue_checker #(
  parameter int TGT_W      = 10,
  parameter int INTR_COUNT = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrlReset,
  input logic             evtValid,
  input logic             evtReady,
  input logic [TGT_W-1:0] evtTarget,
  input logic             memReq,
  input logic             memWrite,
  input logic [63:0]      memAddr,
  input logic             memAck,
  input logic             memErr,
  input logic             irq
);
  assert_ready_low_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> !evtReady);

  assert_irq_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(memReq && memWrite && memAck && !memErr));

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck && !ctrlReset) |=> (memReq && $stable(memAddr) && $stable(memWrite)));

  assert_drop_no_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && evtReady && evtTarget >= TGT_W'(INTR_COUNT) && !ctrlReset) |=> (!memReq && evtReady));

  assert_reset_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlReset |=> (evtReady && !memReq && !irq));
endmodule

bind event_ring_enqueue event_ring_enqueue_checker #(.TGT_W(TGT_W), .INTR_COUNT(INTR_COUNT)) u_checker (
  .clk(clk), .rst_n(rst_n), .ctrlReset(ctrlReset), .evtValid(evtValid),
  .evtReady(evtReady), .evtTarget(evtTarget), .memReq(memReq),
  .memWrite(memWrite), .memAddr(memAddr), .memAck(memAck), .memErr(memErr),
  .irq(irq)
);

// File: tb/event_ring_enqueue_bench.sv
`timescale 1ns/1ps
module event_ring_enqueue_bench;
  localparam logic [63:0] TBASE = 64'h0000_0001_0000_1000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctrlReset = 1'b0;
  logic [4:0]   regAddr = '0;
  logic         regWrEn = 1'b0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic         evtValid = 1'b0;
  logic         evtReady;
  logic [63:0]  evtPtr = '0;
  logic [31:0]  evtStatus = '0;
  logic [31:0]  evtControl = '0;
  logic [9:0]   evtTarget = '0;
  logic         memReq, memWrite;
  logic [63:0]  memAddr;
  logic [127:0] memWrData;
  logic         memAck = 1'b0;
  logic         memErr = 1'b0;
  logic [127:0] memRdData = '0;
  logic         irq;

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  int rdCount = 0;
  int irqCount = 0;
  int failWrAt = 0;
  int failRdAt = 0;
  logic [63:0]  lastWrAddr = '0;
  logic [63:0]  lastRdAddr = '0;
  logic [127:0] lastWrData = '0;
  bit done = 0;

  always #2 clk = ~clk;

  event_ring_enqueue u_event_ring_enqueue (
    .clk(clk), .rst_n(rst_n), .ctrlReset(ctrlReset), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .evtValid(evtValid), .evtReady(evtReady), .evtPtr(evtPtr),
    .evtStatus(evtStatus), .evtControl(evtControl), .evtTarget(evtTarget),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWrData(memWrData), .memAck(memAck), .memErr(memErr),
    .memRdData(memRdData), .irq(irq)
  );

  function automatic logic [127:0] tableEntry(input logic [63:0] a);
    if (a == TBASE)          return {48'h0, 16'd2, 64'h0000_0000_0000_2013};
    if (a == TBASE + 64'h10) return {48'h0, 16'd1, 64'h0000_0000_0000_3000};
    return '0;
  endfunction

  // memory model: acknowledges half a cycle after a request is seen
  always @(negedge clk) begin
    if (memReq && !memAck) begin
      memAck = 1'b1;
      if (memWrite) begin
        wrCount++;
        lastWrAddr = memAddr;
        lastWrData = memWrData;
        memErr = (wrCount == failWrAt);
      end else begin
        rdCount++;
        lastRdAddr = memAddr;
        memRdData = tableEntry(memAddr);
        memErr = (rdCount == failRdAt);
      end
    end else begin
      memAck = 1'b0;
      memErr = 1'b0;
    end
    if (irq) irqCount++;
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regExpect(input logic [4:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData == exp, req, regRdData, exp);
  endtask

  task automatic sendEvent(input logic [63:0] p, input logic [31:0] s, input logic [31:0] c, input logic [9:0] t, input bit expectBusy);
    @(negedge clk);
    evtPtr = p; evtStatus = s; evtControl = c; evtTarget = t; evtValid = 1'b1;
    while (!evtReady) @(negedge clk);
    @(negedge clk);
    evtValid = 1'b0;
    if (expectBusy) check(evtReady == 1'b0, "R13 busy after accept", evtReady, 0);
    while (!evtReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic testResetState;
    regExpect(5'h00, 32'h0, "R12 mgmt after reset");
    check(evtReady == 1'b1 && memReq == 1'b0 && irq == 1'b0, "R12 idle outputs", {evtReady, memReq, irq}, 3'b100);
  endtask

  task automatic testRegisters;
    regWrite(5'h04, 32'h0000_DEAD);
    regWrite(5'h18, 32'h1234_5670);
    regWrite(5'h1C, 32'h0000_00AB);
    regWrite(5'h0C, 32'hFFFF_FFFF);
    regExpect(5'h04, 32'h0000_DEAD, "R1 moderation");
    regExpect(5'h18, 32'h1234_5670, "R1 dequeue low");
    regExpect(5'h1C, 32'h0000_00AB, "R1 dequeue high");
    regExpect(5'h0C, 32'h0, "R1 unused word");
  endtask

  task automatic testFirstFetch;
    regWrite(5'h08, 32'd2);
    regWrite(5'h10, TBASE[31:0]);
    regWrite(5'h14, TBASE[63:32]);
    regExpect(5'h08, 32'd2, "R1 table size");
    regExpect(5'h14, TBASE[63:32], "R1 table base high");
    regWrite(5'h00, 32'h2);
    sendEvent(64'hAAAA_0001, 32'h0100_0000, 32'h0000_8401, 10'd0, 1'b1);
    check(rdCount == 1, "R3 one table read", rdCount, 1);
    check(lastRdAddr == TBASE, "R3 read at table base", lastRdAddr, TBASE);
    check(lastWrAddr == 64'h2000, "R4 write at masked segment base", lastWrAddr, 64'h2000);
    check(lastWrData == {32'h0000_8401, 32'h0100_0000, 64'hAAAA_0001}, "R5 entry layout",
          lastWrData, {32'h0000_8401, 32'h0100_0000, 64'hAAAA_0001});
    check(irqCount == 1, "R6 irq with enable", irqCount, 1);
    regExpect(5'h00, 32'h3, "R6 pending set");
  endtask

  task automatic testManagement;
    regWrite(5'h00, 32'h0);
    regExpect(5'h00, 32'h1, "R2 zero keeps pending, clears enable");
    regWrite(5'h00, 32'h3);
    regExpect(5'h00, 32'h2, "R2 write one clears pending");
  endtask

  task automatic testWalk;
    sendEvent(64'h2, 32'h0, 32'h0, 10'd0, 1'b1);
    check(rdCount == 1, "R6 no fetch inside segment", rdCount, 1);
    check(lastWrAddr == 64'h2010, "R6 pointer advanced by 16", lastWrAddr, 64'h2010);
    sendEvent(64'h3, 32'h0, 32'h0, 10'd0, 1'b1);
    check(lastRdAddr == TBASE + 64'h10, "R7 next table entry", lastRdAddr, TBASE + 64'h10);
    check(lastWrAddr == 64'h3000, "R7 write at new segment", lastWrAddr, 64'h3000);
    sendEvent(64'h4, 32'h0, 32'h0, 10'd0, 1'b1);
    check(lastRdAddr == TBASE, "R8 wrap to table base", lastRdAddr, TBASE);
    check(lastWrAddr == 64'h2000, "R8 write after wrap", lastWrAddr, 64'h2000);
    check(irqCount == 4, "R6 irq per event", irqCount, 4);
  endtask

  task automatic testIrqDisabled;
    regWrite(5'h00, 32'h1);
    sendEvent(64'h5, 32'h0, 32'h0, 10'd0, 1'b1);
    check(irqCount == 4, "R6 no irq when disabled", irqCount, 4);
    regExpect(5'h00, 32'h1, "R6 pending set without enable");
    regWrite(5'h00, 32'h1);
  endtask

  task automatic testDrop;
    int w = wrCount;
    int r = rdCount;
    sendEvent(64'h6, 32'h0, 32'h0, 10'd1, 1'b0);
    check(wrCount == w && rdCount == r, "R9 no memory access", {wrCount, rdCount}, {w, r});
    regExpect(5'h00, 32'h0, "R9 pending unchanged");
  endtask

  task automatic testWriteError;
    failWrAt = wrCount + 1;
    sendEvent(64'h7, 32'h0, 32'h0, 10'd0, 1'b1);
    check(lastWrAddr == 64'h3000, "R10 failed write address", lastWrAddr, 64'h3000);
    regExpect(5'h00, 32'h0, "R10 pending unchanged");
    sendEvent(64'h8, 32'h0, 32'h0, 10'd0, 1'b1);
    check(lastWrAddr == 64'h3000, "R10 retry same address", lastWrAddr, 64'h3000);
    regExpect(5'h00, 32'h1, "R10 pending after good write");
  endtask

  task automatic testFetchError;
    int w = wrCount;
    int r = rdCount;
    failRdAt = rdCount + 1;
    sendEvent(64'h9, 32'h0, 32'h0, 10'd0, 1'b1);
    check(rdCount == r + 1 && lastRdAddr == TBASE, "R11 failed fetch at base", lastRdAddr, TBASE);
    check(wrCount == w, "R11 event dropped", wrCount, w);
    sendEvent(64'hA, 32'h0, 32'h0, 10'd0, 1'b1);
    check(rdCount == r + 2 && lastRdAddr == TBASE, "R11 refetch same entry", lastRdAddr, TBASE);
    check(lastWrAddr == 64'h2000, "R11 write after refetch", lastWrAddr, 64'h2000);
  endtask

  task automatic testCtrlReset;
    @(negedge clk);
    ctrlReset = 1'b1;
    @(negedge clk);
    ctrlReset = 1'b0;
    regExpect(5'h00, 32'h0, "R12 mgmt cleared");
    regExpect(5'h04, 32'h0, "R12 moderation cleared");
    regExpect(5'h08, 32'h0, "R12 table size cleared");
    regExpect(5'h14, 32'h0, "R12 table base cleared");
    regExpect(5'h1C, 32'h0, "R12 dequeue cleared");
  endtask

  task automatic finish;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testResetState();
    testRegisters();
    testFirstFetch();
    testManagement();
    testWalk();
    testIrqDisabled();
    testDrop();
    testWriteError();
    testFetchError();
    testCtrlReset();
    finish();
  end
endmodule